// File: doc/BRIEF.md
# Fast Ethernet PHY Management Register File

This block holds the management registers of a Fast Ethernet PHY behind a parallel register port. A station manager addresses it with a 5-bit PHY address and a 5-bit register index, and issues single-cycle read or write strobes. Only accesses whose PHY address matches the configured address take effect. The block keeps four live registers: control, status, advertisement and link partner. It also returns two fixed identifier words, which are parameters. Every other index reads as zero and ignores writes.

The link input is sampled and edge-detected. A change rewrites the link and negotiation-done bits in the status register, and the link-partner register. A control write with bit 15 set does not store its value. It returns all four live registers to their defaults and then applies the current link level. Read data appears on the output one clock after the read strobe and holds until the next read.

Register indices: 0 control, 1 status, 2 identifier high, 3 identifier low, 4 advertisement, 5 link partner.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, the registers read as follows: control 0x3100, advertisement 0x01E1, status 0x7848 with the link bits clear, and link partner 0x0080.
- R2: A read whose PHY address differs from the configured address returns 0xFFFF. A write with such an address changes no register.
- R3: Read data is registered. It shows the addressed value one clock after the read strobe and holds while no read strobe is present.
- R4: A write to control (index 0) with bit 15 clear stores the written value. A write to advertisement (index 4) stores the written value.
- R5: A write to control with bit 15 set stores nothing. It reloads control 0x3100, status 0x7848, advertisement 0x01E1 and partner 0x0080, and then applies the link level as in R6 and R7.
- R6: When the link comes up, status bits 2 (link) and 5 (negotiation done) are set, and the partner register gains bits 0x0161 in addition to its current bits.
- R7: When the link goes down, status bits 2 and 5 are cleared, and the partner register becomes exactly 0x0080.
- R8: Writes to status (1), identifiers (2, 3), partner (5) and expansion (6) are ignored.
- R9: Indices 6 to 31 read as 0, and writes to them change no register.
- R10: Indices 2 and 3 return the identifier parameters ID_HI and ID_LO (defaults 0x0243 and 0x0C54).
- R11: A change on link_up updates the status and partner registers on the second rising clock edge after the change. At reset release, a link that is already up is applied in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_phy | input | 5 | PHY address this block answers to |
| acc_phy | input | 5 | PHY address of the current access |
| acc_idx | input | 5 | Register index of the current access |
| wr_data | input | 16 | Write data |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| link_up | input | 1 | Current link level |
| rd_data | output | 16 | Registered read data |

## Verification
The assertions assume that cfg_phy is held constant while accesses run. They also assume that link_up is a level signal which changes at most once every few cycles, so that each edge is seen as its own event. The bench drives link_up only at falling clock edges, keeps cfg_phy fixed, and waits three cycles after every link change before the next access. Random accesses mix matched and foreign PHY addresses and cover every index, including control writes that carry the reset bit.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int DATA_W = 16;

    localparam logic [4:0] IDX_CTRL = 5'd0;
    localparam logic [4:0] IDX_STAT = 5'd1;
    localparam logic [4:0] IDX_IDH  = 5'd2;
    localparam logic [4:0] IDX_IDL  = 5'd3;
    localparam logic [4:0] IDX_ADV  = 5'd4;
    localparam logic [4:0] IDX_PART = 5'd5;

    localparam int CTRL_SOFT_RST_BIT = 15;

    localparam logic [DATA_W-1:0] CTRL_DEF    = 16'h3100;
    localparam logic [DATA_W-1:0] STAT_DEF    = 16'h7848;
    localparam logic [DATA_W-1:0] STAT_LINK   = 16'h0024;
    localparam logic [DATA_W-1:0] ADV_DEF     = 16'h01E1;
    localparam logic [DATA_W-1:0] PART_DOWN   = 16'h0080;
    localparam logic [DATA_W-1:0] PART_UP_SET = 16'h0161;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] adv;
        logic [DATA_W-1:0] part;
    } mgmt_regs_t;

    localparam mgmt_regs_t REGS_DEF = '{ctrl: CTRL_DEF, stat: STAT_DEF,
                                        adv: ADV_DEF, part: PART_DOWN};

    function automatic mgmt_regs_t apply_link(mgmt_regs_t r, logic up);
        mgmt_regs_t o = r;
        if (up) begin
            o.stat = r.stat | STAT_LINK;
            o.part = r.part | PART_UP_SET;
        end else begin
            o.stat = r.stat & ~STAT_LINK;
            o.part = PART_DOWN;
        end
        return o;
    endfunction
endpackage

// File: rtl/phy_link_edge.sv
module phy_link_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic link_in,
    output logic link_lvl,
    output logic link_chg
);
    typedef struct packed {
        logic smp;
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.smp  = link_in;
        st_d.prev = st_q.smp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign link_lvl = st_q.smp;
    assign link_chg = st_q.smp ^ st_q.prev;

    // R11: an input change is flagged one clock later
    p_edge_seen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (link_in != link_lvl) |=> link_chg);
endmodule

// File: rtl/phy_reg_core.sv
module phy_reg_core
    import phy_mgmt_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              link_lvl,
    input  logic              link_chg,
    output mgmt_regs_t        regs_q
);
    mgmt_regs_t regs_d;
    logic       soft_rst;

    assign soft_rst = wr_en && (wr_idx == IDX_W'(IDX_CTRL))
                      && wr_data[CTRL_SOFT_RST_BIT];

    always_comb begin
        regs_d = regs_q;
        if (soft_rst) begin
            regs_d = apply_link(REGS_DEF, link_lvl);
        end else begin
            if (wr_en) begin
                if (wr_idx == IDX_W'(IDX_CTRL)) regs_d.ctrl = wr_data;
                if (wr_idx == IDX_W'(IDX_ADV))  regs_d.adv  = wr_data;
            end
            if (link_chg) regs_d = apply_link(regs_d, link_lvl);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= REGS_DEF;
        else        regs_q <= regs_d;
    end

    p_soft_rst_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (regs_q.ctrl == CTRL_DEF) && (regs_q.adv == ADV_DEF));

    p_link_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (link_chg && link_lvl) |=> ((regs_q.stat & STAT_LINK) == STAT_LINK));

    p_link_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_chg && !link_lvl) |=> (regs_q.part == PART_DOWN)
                                    && ((regs_q.stat & STAT_LINK) == '0));

    p_stat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_chg && !soft_rst) |=> $stable(regs_q.stat) && $stable(regs_q.part));
endmodule

// File: rtl/phy_rd_port.sv
module phy_rd_port
    import phy_mgmt_pkg::*;
#(
    parameter int                IDX_W = 5,
    parameter logic [DATA_W-1:0] ID_HI = 16'h0243,
    parameter logic [DATA_W-1:0] ID_LO = 16'h0C54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              addr_hit,
    input  logic [IDX_W-1:0]  rd_idx,
    input  mgmt_regs_t        regs,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] rd_d, rd_q;
    logic [DATA_W-1:0] sel;

    always_comb begin
        case (rd_idx)
            IDX_W'(IDX_CTRL): sel = regs.ctrl;
            IDX_W'(IDX_STAT): sel = regs.stat;
            IDX_W'(IDX_IDH):  sel = ID_HI;
            IDX_W'(IDX_IDL):  sel = ID_LO;
            IDX_W'(IDX_ADV):  sel = regs.adv;
            IDX_W'(IDX_PART): sel = regs.part;
            default:          sel = '0;
        endcase
        rd_d = rd_q;
        if (rd_en) rd_d = addr_hit ? sel : '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    p_foreign_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr_hit) |=> (rd_data == '1));

    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int                ADDR_W = 5,
    parameter int                IDX_W  = 5,
    parameter logic [DATA_W-1:0] ID_HI  = 16'h0243,
    parameter logic [DATA_W-1:0] ID_LO  = 16'h0C54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_phy,
    input  logic [ADDR_W-1:0] acc_phy,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              link_up,
    output logic [DATA_W-1:0] rd_data
);
    logic       hit;
    logic       link_lvl, link_chg;
    mgmt_regs_t regs;

    assign hit = (acc_phy == cfg_phy);

    phy_link_edge link_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_in  (link_up),
        .link_lvl (link_lvl),
        .link_chg (link_chg)
    );

    phy_reg_core #(.IDX_W(IDX_W)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_stb && hit),
        .wr_idx   (acc_idx),
        .wr_data  (wr_data),
        .link_lvl (link_lvl),
        .link_chg (link_chg),
        .regs_q   (regs)
    );

    phy_rd_port #(.IDX_W(IDX_W), .ID_HI(ID_HI), .ID_LO(ID_LO)) rd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_stb),
        .addr_hit (hit),
        .rd_idx   (acc_idx),
        .regs     (regs),
        .rd_data  (rd_data)
    );

    p_foreign_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !hit && !link_chg) |=> $stable(regs));
endmodule

// File: tb/phy_mgmt_regs_tb_top.sv
module phy_mgmt_regs_tb_top;
    localparam logic [4:0]  CFG = 5'd9;
    localparam logic [15:0] IDH = 16'h0243;
    localparam logic [15:0] IDL = 16'h0C54;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  acc_phy = 0, acc_idx = 0;
    logic [15:0] wr_data = 0;
    logic        rd_stb = 0, wr_stb = 0, link_up = 0;
    logic [15:0] rd_data;

    int checks = 0, errors = 0;
    logic [15:0] m_ctrl, m_stat, m_adv, m_part;
    logic        m_link;

    always #2.5 clk = ~clk;

    phy_mgmt_regs dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_phy(CFG), .acc_phy(acc_phy),
        .acc_idx(acc_idx), .wr_data(wr_data), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .link_up(link_up), .rd_data(rd_data)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic m_apply_link(logic up);
        if (up) begin m_stat |= 16'h0024; m_part |= 16'h0161; end
        else begin m_stat &= ~16'h0024; m_part = 16'h0080; end
    endtask

    task automatic m_defaults();
        m_ctrl = 16'h3100; m_stat = 16'h7848; m_adv = 16'h01E1; m_part = 16'h0080;
    endtask

    function automatic logic [15:0] exp_rd(logic [4:0] phy, logic [4:0] idx);
        if (phy != CFG) return 16'hFFFF;
        case (idx)
            5'd0: return m_ctrl;
            5'd1: return m_stat;
            5'd2: return IDH;
            5'd3: return IDL;
            5'd4: return m_adv;
            5'd5: return m_part;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic do_wr(logic [4:0] phy, logic [4:0] idx, logic [15:0] d);
        @(negedge clk);
        acc_phy = phy; acc_idx = idx; wr_data = d; wr_stb = 1;
        @(negedge clk);
        wr_stb = 0;
        if (phy == CFG) begin
            if (idx == 5'd0 && d[15]) begin m_defaults(); m_apply_link(m_link); end
            else if (idx == 5'd0) m_ctrl = d;
            else if (idx == 5'd4) m_adv = d;
        end
    endtask

    task automatic do_rd(string req, logic [4:0] phy, logic [4:0] idx);
        @(negedge clk);
        acc_phy = phy; acc_idx = idx; rd_stb = 1;
        @(negedge clk);
        rd_stb = 0;
        chk(req, rd_data, exp_rd(phy, idx));
    endtask

    task automatic set_link(logic v);
        @(negedge clk);
        link_up = v;
        repeat (3) @(negedge clk);
        if (v != m_link) m_apply_link(v);
        m_link = v;
    endtask

    task automatic hw_reset(logic lk);
        @(negedge clk);
        rst_n = 0; link_up = lk;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_defaults(); m_link = 0;
        repeat (3) @(negedge clk);
        if (lk) m_apply_link(1'b1);
        m_link = lk;
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        hw_reset(1'b0);
        chk("R1 rd_data after reset", rd_data, 16'h0000);
        do_rd("R1 ctrl", CFG, 5'd0);
        do_rd("R1 stat", CFG, 5'd1);
        do_rd("R1 adv", CFG, 5'd4);
        do_rd("R1 part", CFG, 5'd5);
        do_rd("R10 id hi", CFG, 5'd2);
        do_rd("R10 id lo", CFG, 5'd3);
        do_rd("R2 foreign read", CFG ^ 5'd1, 5'd0);
        // R3: hold while idle
        repeat (4) @(negedge clk);
        chk("R3 hold", rd_data, 16'hFFFF);
        do_wr(CFG ^ 5'd4, 5'd4, 16'h0000);
        do_rd("R2 foreign write ignored", CFG, 5'd4);
        do_wr(CFG, 5'd0, 16'h1200);
        do_rd("R4 ctrl stored", CFG, 5'd0);
        do_wr(CFG, 5'd4, 16'h0061);
        do_rd("R4 adv stored", CFG, 5'd4);
        for (int i = 1; i < 7; i++) begin
            if (i == 4) continue;
            do_wr(CFG, 5'(i), 16'hA5A5);
        end
        do_rd("R8 stat ro", CFG, 5'd1);
        do_rd("R8 part ro", CFG, 5'd5);
        do_rd("R8 id ro", CFG, 5'd2);
        do_wr(CFG, 5'd19, 16'hFFFF);
        do_rd("R9 vendor zero", CFG, 5'd19);
        do_rd("R9 expansion zero", CFG, 5'd6);
        set_link(1'b1);
        do_rd("R6 stat up", CFG, 5'd1);
        chk("R6 stat value", rd_data, 16'h786C);
        do_rd("R6 part up", CFG, 5'd5);
        chk("R6 part value", rd_data, 16'h01E1);
        do_wr(CFG, 5'd0, 16'h8000);
        do_rd("R5 ctrl default", CFG, 5'd0);
        do_rd("R5 adv default", CFG, 5'd4);
        do_rd("R5 stat keeps link", CFG, 5'd1);
        set_link(1'b0);
        do_rd("R7 stat down", CFG, 5'd1);
        do_rd("R7 part down", CFG, 5'd5);
        chk("R7 part value", rd_data, 16'h0080);
        // R11: after one edge the update must not have landed yet
        @(negedge clk); link_up = 1; acc_phy = CFG; acc_idx = 5'd1; rd_stb = 1;
        @(negedge clk); rd_stb = 0;
        chk("R11 not yet", rd_data, m_stat);
        repeat (2) @(negedge clk);
        m_apply_link(1'b1); m_link = 1;
        do_rd("R11 applied", CFG, 5'd1);
        hw_reset(1'b1);
        do_rd("R11 link at reset stat", CFG, 5'd1);
        do_rd("R11 link at reset part", CFG, 5'd5);
        for (int n = 0; n < 400; n++) begin
            int unsigned r = $urandom_range(0, 19);
            logic [4:0] ph = ($urandom_range(0, 3) == 0) ? 5'($urandom) : CFG;
            logic [4:0] ix = ($urandom_range(0, 1) == 0) ? 5'($urandom_range(0, 6)) : 5'($urandom);
            if (r == 0) set_link(~m_link);
            else if (r < 8) do_wr(ph, ix, 16'($urandom));
            else do_rd("R4 random read", ph, ix);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule